// File: doc/BRIEF.md
# Store Buffer with Ordering Markers

This block sits between the execute stage and a data-cache write port. It holds stores in program order until they are known to be non-speculative, then writes them to the cache through a valid/ready handshake. It also holds two kinds of ordering marker in the same queue: a full fence and a store fence. Neither marker carries data. Each one leaves the queue once everything older than it has been written.

The pipeline enqueues one entry per cycle. It pulses `retire` to mark the oldest speculative entry as non-speculative, and it pulses `flush` to discard every entry that is still speculative. The buffer drains by itself: whenever a retired entry is allowed to leave, it is offered to the cache with no request from outside.

Normal stores reach the cache strictly in program order. A retired non-temporal store is preferred and may overtake older normal stores, but it may not pass any marker. The load unit watches `load_permit`. This signal drops while a full fence is queued behind older entries. Without such a fence, loads may run ahead of buffered stores.

Top module: `store_buffer`

## Requirements
- R1: After reset `empty` is 1, `full` is 0, `load_permit` is 1 and `wr_valid` is 0.
- R2: A store is offered on the cache port only after it has been retired. A speculative store that is later flushed is never offered.
- R3: Normal stores (`in_kind` 0, `in_nt` 0) are written in program order. A retired non-temporal store (`in_kind` 0, `in_nt` 1) with no marker older than it is offered before any older normal store that is not already on offer. Among non-temporal stores, the oldest goes first.
- R4: A store fence (`in_kind` 2) keeps every younger store, non-temporal ones included, off the port until all older stores are written and the marker has left.
- R5: A full fence (`in_kind` 1, and also code 3) drives `load_permit` to 0 while it sits behind at least one older entry. Otherwise `load_permit` is 1, even with stores pending.
- R6: A retired marker at the head leaves in one cycle without raising `wr_valid`.
- R7: Draining needs no request. Once a store is offered and not accepted, `wr_valid` stays 1 and `wr_addr`/`wr_data`/`wr_nt` hold until `wr_ready` is 1.
- R8: `full` is 1 when the queue holds DEPTH (8) entries. An entry presented while `full` is 1 is dropped.
- R9: A `flush` pulse discards every unretired entry in one cycle, keeps all retired entries, and also drops an entry presented in the same cycle.
- R10: `retire` marks only the oldest unretired entry. A `retire` with no unretired entry has no effect.
- R11: `empty` is 1 exactly when no store or marker entry remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Enqueue an entry this cycle |
| in_kind | input | 2 | 0 store, 1 full fence, 2 store fence, 3 full fence |
| in_nt | input | 1 | Store is non-temporal (ignored for markers) |
| in_addr | input | AW | Store address |
| in_data | input | DW | Store data |
| full | output | 1 | Queue holds DEPTH entries; enqueue stalls |
| retire | input | 1 | Mark the oldest unretired entry retired |
| flush | input | 1 | Discard all unretired entries |
| wr_valid | output | 1 | Store offered to the cache |
| wr_addr | output | AW | Offered address |
| wr_data | output | DW | Offered data |
| wr_nt | output | 1 | Offered store is non-temporal |
| wr_ready | input | 1 | Cache accepts the offered store |
| load_permit | output | 1 | Younger loads may execute |
| empty | output | 1 | No entries remain |

## Verification
Four input patterns drive the ordering logic. A normal–normal–non-temporal group with the port stalled shows the non-temporal store overtaking the second normal store while the first stays on offer. The same group with a store fence in the middle shows the non-temporal store held back until the marker has left. A store, a full fence and a younger store show `load_permit` dropping only while the fence has an older entry ahead of it. Fill-to-full, flush-with-enqueue and retire-on-nothing patterns separate correct handling of speculative entries from designs that commit, keep or count them wrongly.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    typedef enum logic [1:0] {
        ENT_STORE       = 2'd0,
        ENT_FULL_FENCE  = 2'd1,
        ENT_STORE_FENCE = 2'd2
    } ent_kind_e;

    typedef struct packed {
        ent_kind_e kind;
        logic      nt;
    } ent_meta_t;

    // Code 3 is folded onto the full fence, the stronger marker.
    function automatic ent_meta_t make_meta(input logic [1:0] code, input logic nt);
        ent_meta_t m;
        case (code)
            2'd0:    m.kind = ENT_STORE;
            2'd2:    m.kind = ENT_STORE_FENCE;
            default: m.kind = ENT_FULL_FENCE;
        endcase
        m.nt = (code == 2'd0) ? nt : 1'b0;
        return m;
    endfunction

    function automatic logic is_marker(input ent_meta_t m);
        return m.kind != ENT_STORE;
    endfunction

    function automatic logic is_normal_store(input ent_meta_t m);
        return (m.kind == ENT_STORE) && !m.nt;
    endfunction

    function automatic logic is_nt_store(input ent_meta_t m);
        return (m.kind == ENT_STORE) && m.nt;
    endfunction

endpackage

// File: rtl/sb_queue.sv
module sb_queue
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 64,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enq_en,
    input  ent_meta_t                  enq_meta,
    input  logic [AW-1:0]              enq_addr,
    input  logic [DW-1:0]              enq_data,
    input  logic                       rem_en,
    input  logic [IW-1:0]              rem_idx,
    input  logic                       retire_en,
    input  logic                       flush,
    output ent_meta_t [DEPTH-1:0]      q_meta,
    output logic [DEPTH-1:0][AW-1:0]   q_addr,
    output logic [DEPTH-1:0][DW-1:0]   q_data,
    output logic [CW-1:0]              count,
    output logic [CW-1:0]              ret_cnt
);

    logic          ret_inc;
    logic [CW-1:0] cnt_rm;
    logic [CW-1:0] ret_n;
    logic [CW-1:0] cnt_n;
    logic [IW-1:0] wr_idx;

    // Retired entries always form the oldest prefix, so a count describes them.
    always_comb begin
        ret_inc = retire_en && (ret_cnt < count);
        cnt_rm  = count - CW'(rem_en);
        ret_n   = ret_cnt + CW'(ret_inc) - CW'(rem_en);
        cnt_n   = flush ? ret_n : (cnt_rm + CW'(enq_en));
        wr_idx  = IW'(cnt_rm);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            ret_cnt <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                q_meta[i] <= '0;
                q_addr[i] <= '0;
                q_data[i] <= '0;
            end
        end else begin
            // Close the gap left by a removed entry.
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (rem_en && (i >= int'(rem_idx))) begin
                    q_meta[i] <= q_meta[i+1];
                    q_addr[i] <= q_addr[i+1];
                    q_data[i] <= q_data[i+1];
                end
            end
            if (enq_en) begin
                q_meta[wr_idx] <= enq_meta;
                q_addr[wr_idx] <= enq_addr;
                q_data[wr_idx] <= enq_data;
            end
            count   <= cnt_n;
            ret_cnt <= ret_n;
        end
    end

endmodule

// File: rtl/sb_select.sv
module sb_select
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  ent_meta_t [DEPTH-1:0] q_meta,
    input  logic [CW-1:0]         count,
    input  logic [CW-1:0]         ret_cnt,
    input  logic                  wr_ready,
    output logic                  pick_valid,
    output logic                  pick_store,
    output logic [IW-1:0]         pick_idx,
    output logic                  load_permit
);

    logic [DEPTH-1:0] live, done, norm, ntst, mark, ffen;

    for (genvar g = 0; g < DEPTH; g++) begin : g_class
        assign live[g] = count > CW'(g);
        assign done[g] = ret_cnt > CW'(g);
        assign norm[g] = is_normal_store(q_meta[g]);
        assign ntst[g] = is_nt_store(q_meta[g]);
        assign mark[g] = is_marker(q_meta[g]);
        assign ffen[g] = q_meta[g].kind == ENT_FULL_FENCE;
    end

    logic          lock_q;
    logic [IW-1:0] lock_idx_q;
    logic          nt_hit, ot_hit, ot_store, ff_behind;
    logic [IW-1:0] nt_idx, ot_idx;

    always_comb begin
        logic seen_n, seen_m;
        seen_n    = 1'b0;
        seen_m    = 1'b0;
        nt_hit    = 1'b0;
        ot_hit    = 1'b0;
        ot_store  = 1'b0;
        ff_behind = 1'b0;
        nt_idx    = '0;
        ot_idx    = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (live[i] && done[i]) begin
                if (ntst[i] && !seen_m && !nt_hit) begin
                    nt_hit = 1'b1;
                    nt_idx = IW'(i);
                end
                if (norm[i] && !seen_n && !seen_m && !ot_hit) begin
                    ot_hit   = 1'b1;
                    ot_store = 1'b1;
                    ot_idx   = IW'(i);
                end
                if (mark[i] && (i == 0)) begin
                    ot_hit = 1'b1;
                    ot_idx = '0;
                end
            end
            if (live[i]) begin
                seen_n = seen_n | norm[i];
                seen_m = seen_m | mark[i];
                if ((i != 0) && ffen[i]) ff_behind = 1'b1;
            end
        end
    end

    always_comb begin
        if (lock_q) begin
            pick_valid = 1'b1;
            pick_store = 1'b1;
            pick_idx   = lock_idx_q;
        end else if (nt_hit) begin
            pick_valid = 1'b1;
            pick_store = 1'b1;
            pick_idx   = nt_idx;
        end else begin
            pick_valid = ot_hit;
            pick_store = ot_hit && ot_store;
            pick_idx   = ot_idx;
        end
        load_permit = !ff_behind;
    end

    // An offered store stays chosen until the port takes it.
    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q     <= 1'b0;
            lock_idx_q <= '0;
        end else begin
            lock_q     <= pick_valid && pick_store && !wr_ready;
            lock_idx_q <= pick_idx;
        end
    end

endmodule

// File: rtl/store_buffer.sv
module store_buffer
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 64,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    in_kind,
    input  logic          in_nt,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic          full,
    input  logic          retire,
    input  logic          flush,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          wr_nt,
    input  logic          wr_ready,
    output logic          load_permit,
    output logic          empty
);

    ent_meta_t [DEPTH-1:0]     q_meta;
    logic [DEPTH-1:0][AW-1:0]  q_addr;
    logic [DEPTH-1:0][DW-1:0]  q_data;
    logic [CW-1:0]             q_count;
    logic [CW-1:0]             q_ret;
    logic                      pick_valid, pick_store;
    logic [IW-1:0]             pick_idx;
    logic                      enq_en, rem_en;

    assign full   = q_count == CW'(DEPTH);
    assign empty  = q_count == '0;
    assign enq_en = in_valid && !full && !flush;

    sb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .enq_en    (enq_en),
        .enq_meta  (make_meta(in_kind, in_nt)),
        .enq_addr  (in_addr),
        .enq_data  (in_data),
        .rem_en    (rem_en),
        .rem_idx   (pick_idx),
        .retire_en (retire),
        .flush     (flush),
        .q_meta    (q_meta),
        .q_addr    (q_addr),
        .q_data    (q_data),
        .count     (q_count),
        .ret_cnt   (q_ret)
    );

    sb_select #(.DEPTH(DEPTH)) u_select (
        .clk         (clk),
        .rst         (rst),
        .q_meta      (q_meta),
        .count       (q_count),
        .ret_cnt     (q_ret),
        .wr_ready    (wr_ready),
        .pick_valid  (pick_valid),
        .pick_store  (pick_store),
        .pick_idx    (pick_idx),
        .load_permit (load_permit)
    );

    assign wr_valid = pick_valid && pick_store;
    assign wr_addr  = q_addr[pick_idx];
    assign wr_data  = q_data[pick_idx];
    assign wr_nt    = q_meta[pick_idx].nt;
    // Markers pop on their own; stores leave on the handshake.
    assign rem_en   = pick_valid && (!pick_store || wr_ready);

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          wr_nt,
    input logic          load_permit,
    input logic          empty,
    input logic          flush,
    input logic [CW-1:0] count,
    input logic [CW-1:0] ret_cnt
);

    assert_offer_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_nt)));

    assert_offer_retired_R2: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (ret_cnt != '0));

    assert_block_needs_entries_R5: assert property (@(posedge clk) disable iff (rst)
        !load_permit |-> (count >= CW'(2)));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    assert_flush_leaves_retired_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (ret_cnt == count));

    assert_retire_bound_R10: assert property (@(posedge clk) disable iff (rst)
        ret_cnt <= count);

    assert_empty_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        empty |-> (!wr_valid && load_permit));

endmodule

bind store_buffer sb_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_sb_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_nt       (wr_nt),
    .load_permit (load_permit),
    .empty       (empty),
    .flush       (flush),
    .count       (q_count),
    .ret_cnt     (q_ret)
);

// File: tb/tb_store_buffer.sv
`timescale 1ns/1ps
module tb_store_buffer;

    localparam int AW = 32;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid, in_nt, retire, flush, wr_ready;
    logic [1:0]    in_kind;
    logic [AW-1:0] in_addr;
    logic [DW-1:0] in_data;
    logic          full, wr_valid, wr_nt, load_permit, empty;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    store_buffer dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_kind(in_kind), .in_nt(in_nt),
        .in_addr(in_addr), .in_data(in_data), .full(full),
        .retire(retire), .flush(flush),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_nt(wr_nt), .wr_ready(wr_ready),
        .load_permit(load_permit), .empty(empty)
    );

    function automatic logic [DW-1:0] dat(input logic [7:0] a);
        return {8{a}};
    endfunction

    typedef struct packed {
        logic       en;
        logic [1:0] kind;
        logic       nt;
        logic [7:0] a;
        logic       ret;
        logic       fl;
        logic       rdy;
        logic       ev;
        logic [7:0] ea;
        logic       elp;
        logic       emt;
        logic [3:0] req;
    } row_t;

    // Expected fields describe the state before the row's inputs take effect.
    localparam int ROWS = 22;
    localparam row_t TBL [ROWS] = '{
        '{1'b1,2'd0,1'b0,8'h10, 1'b0,1'b0,1'b1, 1'b0,8'h00,1'b1,1'b1, 4'd11}, // R11
        '{1'b1,2'd0,1'b0,8'h11, 1'b1,1'b0,1'b1, 1'b0,8'h00,1'b1,1'b0, 4'd2},  // R2
        '{1'b1,2'd0,1'b1,8'h12, 1'b1,1'b0,1'b0, 1'b1,8'h10,1'b1,1'b0, 4'd7},  // R7
        '{1'b0,2'd0,1'b0,8'h00, 1'b1,1'b0,1'b0, 1'b1,8'h10,1'b1,1'b0, 4'd7},
        '{1'b0,2'd0,1'b0,8'h00, 1'b0,1'b0,1'b1, 1'b1,8'h10,1'b1,1'b0, 4'd7},
        '{1'b0,2'd0,1'b0,8'h00, 1'b0,1'b0,1'b1, 1'b1,8'h12,1'b1,1'b0, 4'd3},  // R3 nt passes
        '{1'b0,2'd0,1'b0,8'h00, 1'b0,1'b0,1'b1, 1'b1,8'h11,1'b1,1'b0, 4'd3},
        '{1'b1,2'd0,1'b0,8'h20, 1'b0,1'b0,1'b1, 1'b0,8'h00,1'b1,1'b1, 4'd11},
        '{1'b1,2'd2,1'b0,8'h00, 1'b1,1'b0,1'b1, 1'b0,8'h00,1'b1,1'b0, 4'd2},
        '{1'b1,2'd0,1'b1,8'h21, 1'b1,1'b0,1'b0, 1'b1,8'h20,1'b1,1'b0, 4'd4},  // R4
        '{1'b0,2'd0,1'b0,8'h00, 1'b1,1'b0,1'b0, 1'b1,8'h20,1'b1,1'b0, 4'd4},
        '{1'b0,2'd0,1'b0,8'h00, 1'b0,1'b0,1'b1, 1'b1,8'h20,1'b1,1'b0, 4'd4},
        '{1'b0,2'd0,1'b0,8'h00, 1'b0,1'b0,1'b1, 1'b0,8'h00,1'b1,1'b0, 4'd6},  // R6
        '{1'b0,2'd0,1'b0,8'h00, 1'b0,1'b0,1'b1, 1'b1,8'h21,1'b1,1'b0, 4'd4},
        '{1'b1,2'd0,1'b0,8'h30, 1'b0,1'b0,1'b0, 1'b0,8'h00,1'b1,1'b1, 4'd11},
        '{1'b1,2'd1,1'b0,8'h00, 1'b1,1'b0,1'b0, 1'b0,8'h00,1'b1,1'b0, 4'd5},  // R5
        '{1'b1,2'd0,1'b0,8'h31, 1'b0,1'b0,1'b0, 1'b1,8'h30,1'b0,1'b0, 4'd5},
        '{1'b0,2'd0,1'b0,8'h00, 1'b1,1'b0,1'b0, 1'b1,8'h30,1'b0,1'b0, 4'd5},
        '{1'b0,2'd0,1'b0,8'h00, 1'b1,1'b0,1'b1, 1'b1,8'h30,1'b0,1'b0, 4'd5},
        '{1'b0,2'd0,1'b0,8'h00, 1'b0,1'b0,1'b1, 1'b0,8'h00,1'b1,1'b0, 4'd6},
        '{1'b0,2'd0,1'b0,8'h00, 1'b0,1'b0,1'b1, 1'b1,8'h31,1'b1,1'b0, 4'd5},
        '{1'b0,2'd0,1'b0,8'h00, 1'b0,1'b0,1'b1, 1'b0,8'h00,1'b1,1'b1, 4'd11}
    };

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        in_valid = 1'b0; in_kind = 2'd0; in_nt = 1'b0; in_addr = '0; in_data = '0;
        retire = 1'b0; flush = 1'b0; wr_ready = 1'b0;
    endtask

    // Drive for one clock edge, starting and ending at a falling edge.
    task automatic cyc(input logic en, input logic [1:0] k, input logic nt, input logic [7:0] a,
                       input logic r, input logic f, input logic rdy);
        in_valid = en; in_kind = k; in_nt = nt; in_addr = AW'(a); in_data = dat(a);
        retire = r; flush = f; wr_ready = rdy;
        @(negedge clk);
        idle();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(64'(empty), 64'd1, "R1", "empty");
        chk(64'(full), 64'd0, "R1", "full");
        chk(64'(load_permit), 64'd1, "R1", "load_permit");
        chk(64'(wr_valid), 64'd0, "R1", "wr_valid");

        for (int i = 0; i < ROWS; i++) begin
            string tag;
            tag = $sformatf("R%0d", TBL[i].req);
            chk(64'(wr_valid), 64'(TBL[i].ev), tag, $sformatf("row %0d wr_valid", i));
            if (TBL[i].ev) begin
                chk(64'(wr_addr), 64'(TBL[i].ea), tag, $sformatf("row %0d wr_addr", i));
                chk(wr_data, dat(TBL[i].ea), tag, $sformatf("row %0d wr_data", i));
            end
            chk(64'(load_permit), 64'(TBL[i].elp), tag, $sformatf("row %0d load_permit", i));
            chk(64'(empty), 64'(TBL[i].emt), tag, $sformatf("row %0d empty", i));
            cyc(TBL[i].en, TBL[i].kind, TBL[i].nt, TBL[i].a, TBL[i].ret, TBL[i].fl, TBL[i].rdy);
        end

        // R8: fill to depth, extra entry dropped, R3 order on drain
        for (int k = 0; k < 8; k++) cyc(1'b1, 2'd0, 1'b0, 8'h40 + 8'(k), 1'b0, 1'b0, 1'b0);
        chk(64'(full), 64'd1, "R8", "full at depth");
        cyc(1'b1, 2'd0, 1'b0, 8'h48, 1'b0, 1'b0, 1'b0);
        chk(64'(full), 64'd1, "R8", "full after dropped enqueue");
        for (int k = 0; k < 9; k++) cyc(1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) begin
            chk(64'(wr_addr), 64'(8'h40 + 8'(k)), "R3", "in-order drain address");
            chk(64'(wr_valid), 64'd1, "R3", "in-order drain valid");
            cyc(1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        end
        chk(64'(wr_valid), 64'd0, "R8", "dropped entry never offered");
        chk(64'(empty), 64'd1, "R8", "empty after drain");

        // R10: retire with nothing pending must not pre-retire a later store
        cyc(1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        cyc(1'b1, 2'd0, 1'b0, 8'h49, 1'b0, 1'b0, 1'b0);
        chk(64'(wr_valid), 64'd0, "R10", "stray retire ignored");
        cyc(1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        chk(64'(empty), 64'd1, "R9", "flush drops unretired store");

        // R9: flush keeps retired, drops unretired and same-cycle enqueue
        cyc(1'b1, 2'd0, 1'b0, 8'h50, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 2'd0, 1'b0, 8'h51, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 2'd0, 1'b0, 8'h52, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        chk(64'(wr_addr), 64'h50, "R9", "retired store offered");
        cyc(1'b1, 2'd0, 1'b0, 8'h53, 1'b0, 1'b1, 1'b0);
        chk(64'(empty), 64'd0, "R9", "retired store kept");
        chk(64'(wr_valid), 64'd1, "R9", "kept store still offered");
        cyc(1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        chk(64'(empty), 64'd1, "R9", "unretired and same-cycle entries gone");

        // R5: code 3 acts as a full fence
        cyc(1'b1, 2'd0, 1'b0, 8'h60, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 2'd3, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 2'd0, 1'b0, 8'h61, 1'b0, 1'b0, 1'b0);
        chk(64'(load_permit), 64'd0, "R5", "code 3 blocks loads");
        cyc(1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        chk(64'(empty), 64'd1, "R9", "flush clears markers");
        chk(64'(load_permit), 64'd1, "R5", "loads free after flush");

        summary();
        $finish;
    end

endmodule